// File: doc/BRIEF.md
# Trimmed-Rate Time-of-Day Counter

This block keeps a 64-bit time-of-day value for precision time protocol use. Each tick of the count stands for 32 ns, so software gets nanoseconds by shifting the count left by five bits. The rate is trimmed finely through a 32-bit phase accumulator. Every clock cycle the accumulator adds a programmable step, and each carry out of it advances the time by one tick. A larger step makes the clock run faster. A smaller step makes it run slower.

Software reaches the block over a simple word-addressed register bus.

- Time is loaded as a low word followed by a high word.
- Time is read as a low word followed by a high word, and the two words always form one consistent sample.

Two external trigger inputs each take a snapshot of the time into their own register pair. A comparator flags the moment the time first reaches a programmed target. The flags sit in an event register that software clears by writing ones. Each flag can be routed to a single interrupt line.

Top module: `ptp_tod_clock`

## Requirements
- R1: After `rst_n` is deasserted, these registers read as follows:
  - the step register (offset 2) reads 0xA0000000;
  - control (offset 0), event (offset 1) and the high time word (offset 9) read 0;
  - `irq` is 0.
- R2: On every clock the step is added to the 32-bit accumulator (offset 3, readable and writable). Each carry out adds one to the 64-bit time, including a carry from the low word into the high word. Starting from accumulator 0, N cycles at step S advance the time by floor(S·N / 2^32).
- R3: A write to the low time word (offset 8) only fills a shadow register and leaves the running time unchanged. A write to the high time word (offset 9) loads the high word and the shadow together.
- R4: A read of the low time word latches the high word at that moment. The next read of offset 9 returns this latched value, even if the time has been rewritten in between.
- R5: Control bit 0 is a soft reset. While it is 1, the following are held at their R1 values and bus writes to them are ignored:
  - time and accumulator;
  - the step register;
  - target, snapshots and events.
  The control register itself stays writable.
- R6: A rising edge on `aux_trig[0]` copies the time into the first snapshot pair (offsets 12/13) and sets event bit 2. A rising edge on `aux_trig[1]` copies the time into the second pair (offsets 14/15) and sets event bit 3. The input is synchronised through two flops, so the capture happens at the third clock edge after the input rises.
- R7: Event bit 1 is set in the cycle after the time first becomes greater than or equal to the 64-bit target (offsets 10 low / 11 high).
- R8: Writing event (offset 1) clears every bit written as 1 and leaves bits written as 0 unchanged. A flag that sets in the same cycle as its clear stays set.
- R9: `irq` is the OR over k = 1..4 of event bit k AND control bit k. Event bit 4 is never set.
- R10: Offsets 4 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Bus access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on offset |
| aux_trig | input | 2 | Asynchronous snapshot triggers |
| irq | output | 1 | Masked OR of event flags |

## Verification
A wrong accumulator or step shows up at the time registers after a known number of cycles. The tick count drifts from floor(S·N/2^32) within one carry period, so the bench runs several steps over fixed windows with the clock stopped before and after each window. A broken shadow or latched high word appears at the very next bus read, as a word pair that does not match what was written. A faulty snapshot or flag path is visible three edges after a trigger, in the snapshot pair, the event register and `irq`.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 4;
  localparam logic [WORD_W-1:0] STEP_RST = 32'hA000_0000;

  localparam logic [ADDR_W-1:0] OFS_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_EVENT   = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_STEP    = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_ACC     = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_TOD_LO  = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_TOD_HI  = 4'd9;
  localparam logic [ADDR_W-1:0] OFS_TGT_LO  = 4'd10;
  localparam logic [ADDR_W-1:0] OFS_TGT_HI  = 4'd11;
  localparam logic [ADDR_W-1:0] OFS_SNAP0LO = 4'd12;
  localparam logic [ADDR_W-1:0] OFS_SNAP0HI = 4'd13;
  localparam logic [ADDR_W-1:0] OFS_SNAP1LO = 4'd14;
  localparam logic [ADDR_W-1:0] OFS_SNAP1HI = 4'd15;

  localparam int N_TRIG = 2;
endpackage

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import ptp_tod_pkg::*;
#(
  parameter int W = WORD_W,
  parameter logic [W-1:0] STEP_INIT = W'(STEP_RST)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           step_we,
  input  logic           acc_we,
  input  logic           lo_we,
  input  logic           hi_we,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   step_q,
  output logic [W-1:0]   acc_q,
  output logic [2*W-1:0] tod_q,
  output logic           tick
);
  localparam int TW = 2 * W;

  function automatic logic [W:0] phase_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [W-1:0] shadow_q;
  logic [W:0]   acc_sum;

  assign acc_sum = phase_add(acc_q, step_q);
  assign tick    = acc_sum[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= STEP_INIT;
      acc_q    <= '0;
      tod_q    <= '0;
      shadow_q <= '0;
    end else if (soft_rst) begin
      step_q   <= STEP_INIT;
      acc_q    <= '0;
      tod_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (step_we) step_q <= wdata;
      acc_q <= acc_we ? wdata : acc_sum[W-1:0];
      if (lo_we) shadow_q <= wdata;
      if (hi_we) tod_q <= {wdata, shadow_q};
      else if (tick) tod_q <= tod_q + TW'(1);
    end
  end

  p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !hi_we) |=> ((tod_q - $past(tod_q)) <= TW'(1)));

  p_time_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && hi_we) |=> (tod_q == {$past(wdata), $past(shadow_q)}));

  p_soft_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tod_q == '0 && step_q == STEP_INIT && acc_q == '0));
endmodule

// File: rtl/ptp_trig_snap.sv
module ptp_trig_snap #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          trig,
  input  logic [TW-1:0] tod_in,
  output logic [TW-1:0] snap_q,
  output logic          hit
);
  logic [2:0] sync_q;

  assign hit = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      snap_q <= '0;
    end else if (soft_rst) begin
      sync_q <= '0;
      snap_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], trig};
      if (hit) snap_q <= tod_in;
    end
  end

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !soft_rst) |=> (snap_q == $past(tod_in)));
endmodule

// File: rtl/ptp_event_unit.sv
module ptp_event_unit #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [TW-1:0] tod_in,
  input  logic [TW-1:0] target_in,
  input  logic          snap0_hit,
  input  logic          snap1_hit,
  input  logic          clr_we,
  input  logic [4:1]    clr_bits,
  input  logic [4:1]    mask,
  output logic [4:1]    ev_q,
  output logic          irq
);
  logic       reach;
  logic       reach_q;
  logic [4:1] set_v;
  logic [4:1] clr_v;

  assign reach = (tod_in >= target_in);
  assign set_v = {1'b0, snap1_hit, snap0_hit, reach & ~reach_q};
  assign clr_v = clr_we ? clr_bits : 4'b0;
  assign irq   = |(ev_q & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q    <= '0;
      reach_q <= 1'b1;
    end else if (soft_rst) begin
      ev_q    <= '0;
      reach_q <= 1'b1;
    end else begin
      ev_q    <= (ev_q & ~clr_v) | set_v;
      reach_q <= reach;
    end
  end

  p_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && reach && !reach_q) |=> ev_q[1]);

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !soft_rst) |=> ((ev_q & $past(clr_bits & ~set_v)) == 4'b0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && set_v != 4'b0) |=> ((ev_q & $past(set_v)) == $past(set_v)));

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 4'b0) |-> !irq);
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import ptp_tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [N_TRIG-1:0] aux_trig,
  output logic              irq
);
  localparam int TW = 2 * WORD_W;

  logic              wr_en;
  logic              rd_lo;
  logic [4:0]        ctrl_q;
  logic              soft_rst;
  logic [WORD_W-1:0] step_q;
  logic [WORD_W-1:0] acc_q;
  logic [TW-1:0]     tod_q;
  logic              tick;
  logic [TW-1:0]     tgt_q;
  logic [WORD_W-1:0] hi_hold_q;
  logic [4:1]        ev_q;
  logic [TW-1:0]     snap   [N_TRIG];
  logic [N_TRIG-1:0] hits;

  assign wr_en    = reg_sel & reg_wr;
  assign rd_lo    = reg_sel & ~reg_wr & (reg_addr == OFS_TOD_LO);
  assign soft_rst = ctrl_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      tgt_q     <= '0;
      hi_hold_q <= '0;
    end else begin
      if (wr_en && reg_addr == OFS_CTRL) ctrl_q <= reg_wdata[4:0];
      if (rd_lo) hi_hold_q <= tod_q[TW-1:WORD_W];
      if (soft_rst) tgt_q <= '0;
      else if (wr_en && reg_addr == OFS_TGT_LO) tgt_q[WORD_W-1:0] <= reg_wdata;
      else if (wr_en && reg_addr == OFS_TGT_HI) tgt_q[TW-1:WORD_W] <= reg_wdata;
    end
  end

  ptp_tod_core #(.W(WORD_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .step_we  (wr_en && reg_addr == OFS_STEP),
    .acc_we   (wr_en && reg_addr == OFS_ACC),
    .lo_we    (wr_en && reg_addr == OFS_TOD_LO),
    .hi_we    (wr_en && reg_addr == OFS_TOD_HI),
    .wdata    (reg_wdata),
    .step_q   (step_q),
    .acc_q    (acc_q),
    .tod_q    (tod_q),
    .tick     (tick)
  );

  for (genvar g = 0; g < N_TRIG; g++) begin : g_snap
    ptp_trig_snap #(.TW(TW)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .trig     (aux_trig[g]),
      .tod_in   (tod_q),
      .snap_q   (snap[g]),
      .hit      (hits[g])
    );
  end

  ptp_event_unit #(.TW(TW)) u_event (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .tod_in    (tod_q),
    .target_in (tgt_q),
    .snap0_hit (hits[0]),
    .snap1_hit (hits[1]),
    .clr_we    (wr_en && reg_addr == OFS_EVENT),
    .clr_bits  (reg_wdata[4:1]),
    .mask      (ctrl_q[4:1]),
    .ev_q      (ev_q),
    .irq       (irq)
  );

  always_comb begin
    case (reg_addr)
      OFS_CTRL:    reg_rdata = {{(WORD_W-5){1'b0}}, ctrl_q};
      OFS_EVENT:   reg_rdata = {{(WORD_W-5){1'b0}}, ev_q, 1'b0};
      OFS_STEP:    reg_rdata = step_q;
      OFS_ACC:     reg_rdata = acc_q;
      OFS_TOD_LO:  reg_rdata = tod_q[WORD_W-1:0];
      OFS_TOD_HI:  reg_rdata = hi_hold_q;
      OFS_TGT_LO:  reg_rdata = tgt_q[WORD_W-1:0];
      OFS_TGT_HI:  reg_rdata = tgt_q[TW-1:WORD_W];
      OFS_SNAP0LO: reg_rdata = snap[0][WORD_W-1:0];
      OFS_SNAP0HI: reg_rdata = snap[0][TW-1:WORD_W];
      OFS_SNAP1LO: reg_rdata = snap[1][WORD_W-1:0];
      OFS_SNAP1HI: reg_rdata = snap[1][TW-1:WORD_W];
      default:     reg_rdata = '0;
    endcase
  end

  p_hi_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (hi_hold_q == $past(tod_q[TW-1:WORD_W])));

  p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !tick && !(wr_en && reg_addr == OFS_TOD_HI)) |=> $stable(tod_q));
endmodule

// File: tb/tb_ptp_tod_clock.sv
module tb_ptp_tod_clock;
  localparam logic [3:0] A_CTRL = 0, A_EV = 1, A_STEP = 2, A_ACC = 3, A_GAP = 5;
  localparam logic [3:0] A_TLO = 8, A_THI = 9, A_GLO = 10, A_GHI = 11;
  localparam logic [3:0] A_S0L = 12, A_S0H = 13, A_S1L = 14, A_S1H = 15;
  localparam int NV = 6;
  localparam logic [31:0] V_STEP [NV] = '{32'h4000_0000, 32'h8000_0000, 32'hA000_0000,
                                          32'hFFFF_FFFF, 32'h0000_0001, 32'h2000_0000};
  localparam int V_CYC [NV] = '{40, 64, 40, 40, 40, 24};
  localparam int V_EXP [NV] = '{10, 32, 25, 39, 0, 3};

  logic clk = 0, rst_n = 0, reg_sel = 0, reg_wr = 0, irq;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, rv;
  logic [1:0] aux_trig = 0;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  ptp_tod_clock dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .aux_trig(aux_trig), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_sel = 0;
  endtask

  task automatic load_tod(input logic [31:0] hi, input logic [31:0] lo);
    wr(A_TLO, lo);
    wr(A_THI, hi);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(A_STEP, rv); chk("R1 step", rv, 32'hA000_0000);
    rd(A_CTRL, rv); chk("R1 ctrl", rv, 0);
    rd(A_EV, rv);   chk("R1 event", rv, 0);
    rd(A_TLO, rv);  rd(A_THI, rv); chk("R1 time hi", rv, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(A_GAP, rv);  chk("R10 gap reads zero", rv, 0);

    // R2 rate table
    for (int i = 0; i < NV; i++) begin
      wr(A_STEP, 0); wr(A_ACC, 0); load_tod(0, 0);
      wr(A_STEP, V_STEP[i]);
      repeat (V_CYC[i] - 1) @(negedge clk);
      wr(A_STEP, 0);
      rd(A_TLO, rv); chk($sformatf("R2 rate vec %0d", i), rv, V_EXP[i]);
      rd(A_THI, rv); chk($sformatf("R2 rate hi vec %0d", i), rv, 0);
    end
    rd(A_STEP, rv); chk("R10 step readback", rv, 0);

    // R2 carry into high word
    wr(A_ACC, 0); load_tod(32'h5, 32'hFFFF_FFFF);
    wr(A_STEP, 32'h8000_0000);
    repeat (3) @(negedge clk);
    wr(A_STEP, 0);
    rd(A_TLO, rv); chk("R2 wrap lo", rv, 1);
    rd(A_THI, rv); chk("R2 wrap hi", rv, 6);
    wr(A_ACC, 32'h1234_5678);
    rd(A_ACC, rv); chk("R10 acc readback", rv, 32'h1234_5678);

    // R3 low write alone has no effect
    load_tod(32'h7, 32'h9);
    wr(A_TLO, 32'h123);
    rd(A_TLO, rv); chk("R3 lo alone", rv, 32'h9);
    wr(A_THI, 32'h44);
    rd(A_TLO, rv); chk("R3 pair lo", rv, 32'h123);
    rd(A_THI, rv); chk("R3 pair hi", rv, 32'h44);

    // R4 coherent high word
    load_tod(32'h7, 32'h9);
    rd(A_TLO, rv);
    wr(A_THI, 32'h8);
    rd(A_THI, rv); chk("R4 held hi", rv, 32'h7);
    rd(A_TLO, rv); rd(A_THI, rv); chk("R4 new hi", rv, 32'h8);

    // R7 target, R9 irq, R8 clear
    load_tod(0, 100);
    wr(A_GLO, 105);
    repeat (2) @(negedge clk);
    rd(A_EV, rv); chk("R7 not yet", rv, 0);
    load_tod(0, 105);
    repeat (2) @(negedge clk);
    rd(A_EV, rv); chk("R7 target hit", rv, 32'h2);
    chk("R9 masked off", {31'b0, irq}, 0);
    wr(A_CTRL, 32'hC);
    chk("R9 other masks", {31'b0, irq}, 0);
    wr(A_CTRL, 32'h2);
    chk("R9 irq on", {31'b0, irq}, 1);
    wr(A_EV, 0);
    rd(A_EV, rv); chk("R8 zero write", rv, 32'h2);
    wr(A_EV, 32'h2);
    rd(A_EV, rv); chk("R8 w1c", rv, 0);
    chk("R9 irq off", {31'b0, irq}, 0);
    wr(A_CTRL, 0);
    wr(A_GHI, 32'hFFFF_FFFF);

    // R6 trigger 0
    load_tod(32'h1, 32'h5);
    aux_trig[0] = 1;
    repeat (6) @(negedge clk);
    aux_trig[0] = 0;
    repeat (3) @(negedge clk);
    rd(A_S0L, rv); chk("R6 snap0 lo", rv, 32'h5);
    rd(A_S0H, rv); chk("R6 snap0 hi", rv, 32'h1);
    rd(A_EV, rv);  chk("R6 event bit2", rv, 32'h4);
    wr(A_EV, 32'h4);

    // R6 trigger 1 with same-cycle clear (R8 set wins)
    load_tod(32'h22, 32'h7);
    aux_trig[1] = 1;
    repeat (2) @(negedge clk);
    wr(A_EV, 32'h8);
    aux_trig[1] = 0;
    repeat (3) @(negedge clk);
    rd(A_EV, rv);  chk("R8 set wins", rv, 32'h8);
    rd(A_S1L, rv); chk("R6 snap1 lo", rv, 32'h7);
    rd(A_S1H, rv); chk("R6 snap1 hi", rv, 32'h22);
    rd(A_S0L, rv); chk("R6 snap0 kept", rv, 32'h5);

    // R5 soft reset
    wr(A_STEP, 32'h1234_5678);
    wr(A_CTRL, 32'h1);
    @(negedge clk);
    rd(A_STEP, rv); chk("R5 step held", rv, 32'hA000_0000);
    rd(A_EV, rv);   chk("R5 event cleared", rv, 0);
    load_tod(32'h77, 32'h77);
    rd(A_TLO, rv);  chk("R5 time lo held", rv, 0);
    rd(A_THI, rv);  chk("R5 time hi held", rv, 0);
    rd(A_S1H, rv);  chk("R5 snap cleared", rv, 0);
    rd(A_CTRL, rv); chk("R5 ctrl writable", rv, 32'h1);
    wr(A_CTRL, 0);
    repeat (4) @(negedge clk);
    rd(A_TLO, rv); rd(A_THI, rv); chk("R5 restart hi", rv, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule